// File: doc/BRIEF.md
# Read-After-Write Interlock for a Five-Stage In-Order Pipeline

This block is the operand-freshness controller of an in-order pipeline that runs fetch, decode, execute, memory and writeback in sequence, one instruction per stage. When an instruction sits in decode, its two source register numbers are compared against the destinations of older instructions still in execute, memory or writeback. The block then either freezes fetch and decode or, when forwarding is allowed, routes a younger in-flight result into the operand in place of the register-file value.

A static policy input selects between two schemes. With the interlock-only policy, decode waits until the producer has left writeback. The register file cannot return a value in the same cycle it writes it. With the forwarding policy, decode waits only while the producer is in execute. After that, the memory-stage or writeback-stage result is steered into the decode operand. Each frozen cycle sends an empty slot into execute. A small behavioural datapath is included so the control can be checked end to end. Its execute stage adds operand A, operand B and an immediate, and its eight-entry register file has register 0 fixed at zero.

Top module: `raw_interlock`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fetch_hold`, `decode_hold`, `ex_bubble` and `wb_valid` are 0 and both operand selects are 0, regardless of the input instruction.
- R2: Under the interlock policy (`policy_bypass`=0), a consumer that directly follows its producer is held in decode for 3 extra cycles.
- R3: Under the interlock policy, a consumer is held while any matching writer is in execute, memory or writeback. A gap of one unrelated instruction costs 2 held cycles, a gap of two costs 1, and larger gaps cost 0.
- R4: Under the forwarding policy (`policy_bypass`=1), decode is held only while a matching writer is in execute, so a directly following consumer costs exactly 1 held cycle.
- R5: Operand select encoding: 0 = register file, 1 = memory-stage result, 2 = writeback-stage result, and 3 is never produced. Under the forwarding policy, a match in memory gives 1 and otherwise a match in writeback gives 2. When both stages match, memory (the younger) wins. Under the interlock policy both selects stay 0.
- R6: A source or destination of register 0, or a writer whose write-enable is 0, never causes a hold or a non-zero select.
- R7: `fetch_hold` equals `decode_hold` in every cycle. While it is 1, the input instruction is not taken, and it is taken on the first edge where the hold is 0.
- R8: In every held cycle `ex_bubble` is 1 and no instruction enters execute. Every accepted instruction therefore appears at writeback exactly once, in program order.
- R9: Each retired instruction shows on `wb_data` the sum of its two source register values and its immediate, modulo 2^16. The values are those that program-order execution would give.
- R10: Reset clears all registers to zero. Register 0 always reads as zero, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| policy_bypass | input | 1 | 0 = interlock only, 1 = forwarding |
| in_valid | input | 1 | Instruction present at the fetch input |
| in_wen | input | 1 | Instruction writes a register |
| in_dst | input | 3 | Destination register number |
| in_src_a | input | 3 | First source register number |
| in_src_b | input | 3 | Second source register number |
| in_imm | input | 16 | Immediate added in execute |
| fetch_hold | output | 1 | Fetch register keeps its instruction; input not taken |
| decode_hold | output | 1 | Decode register keeps its instruction |
| ex_bubble | output | 1 | An empty slot is sent into execute this cycle |
| sel_a | output | 2 | Operand A source select (encoding in R5) |
| sel_b | output | 2 | Operand B source select (encoding in R5) |
| wb_valid | output | 1 | An instruction is in writeback |
| wb_dst | output | 3 | Destination of the instruction in writeback |
| wb_data | output | 16 | Result of the instruction in writeback |

## Verification
Some properties are checked on every cycle: the two holds move together, every held cycle raises the bubble and leaves execute empty, the decode instruction stays unchanged while held, the selects stay at 0 under the interlock policy and never take code 3, and a forwarding-policy hold never lasts two cycles in a row. The exact number of held cycles for each producer–consumer distance, the priority of the memory stage over writeback, and the values that retire can only be shown by the bench's instruction sequences. The bench runs each sequence under both policies and compares the results against a program-order model.

// File: rtl/ri_pkg.sv
package ri_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned NREGS  = 8;
    localparam int unsigned RIDX_W = $clog2(NREGS);
    localparam int unsigned NSRC   = 2;

    typedef logic [RIDX_W-1:0] ridx_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_MEM = 2'd1,
        SEL_WB  = 2'd2
    } opsel_e;

    // instruction as held in fetch and decode
    typedef struct packed {
        logic  valid;
        logic  wen;
        ridx_t dst;
        ridx_t src_a;
        ridx_t src_b;
        word_t imm;
    } instr_t;

    // instruction with resolved operands, entering execute
    typedef struct packed {
        logic  valid;
        logic  wen;
        ridx_t dst;
        word_t opa;
        word_t opb;
        word_t imm;
    } exec_t;

    // instruction with its result (memory and writeback stages)
    typedef struct packed {
        logic  valid;
        logic  wen;
        ridx_t dst;
        word_t res;
    } done_t;

    // what the hazard comparators need from a downstream stage
    typedef struct packed {
        logic  valid;
        logic  wen;
        ridx_t dst;
    } tag_t;

    function automatic logic src_hit(input tag_t t, input ridx_t s);
        return t.valid && t.wen && (t.dst != '0) && (t.dst == s);
    endfunction

    // memory stage holds the younger producer, so it is tested first
    function automatic opsel_e pick_sel(input logic fwd_en, input logic hit_m,
                                        input logic hit_w);
        if (!fwd_en)     return SEL_RF;
        else if (hit_m)  return SEL_MEM;
        else if (hit_w)  return SEL_WB;
        else             return SEL_RF;
    endfunction

    function automatic word_t pick_word(input opsel_e s, input word_t rf_v,
                                        input word_t m_v, input word_t w_v);
        case (s)
            SEL_MEM: return m_v;
            SEL_WB:  return w_v;
            default: return rf_v;
        endcase
    endfunction

endpackage

// File: rtl/ri_hazard_detect.sv
module ri_hazard_detect
    import ri_pkg::*;
(
    input  logic   fwd_en,
    input  logic   dec_valid,
    input  ridx_t  dec_src_a,
    input  ridx_t  dec_src_b,
    input  tag_t   tag_x,
    input  tag_t   tag_m,
    input  tag_t   tag_w,
    output logic   stall,
    output opsel_e sel_a,
    output opsel_e sel_b
);

    ridx_t           srcs  [NSRC];
    logic [NSRC-1:0] hit_x;
    logic [NSRC-1:0] hit_m;
    logic [NSRC-1:0] hit_w;
    opsel_e          sels  [NSRC];

    assign srcs[0] = dec_src_a;
    assign srcs[1] = dec_src_b;

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        always_comb begin
            hit_x[gi] = dec_valid && src_hit(tag_x, srcs[gi]);
            hit_m[gi] = dec_valid && src_hit(tag_m, srcs[gi]);
            hit_w[gi] = dec_valid && src_hit(tag_w, srcs[gi]);
            sels[gi]  = pick_sel(fwd_en, hit_m[gi], hit_w[gi]);
        end
    end

    always_comb begin
        if (fwd_en) stall = |hit_x;
        else        stall = (|hit_x) || (|hit_m) || (|hit_w);
    end

    assign sel_a = sels[0];
    assign sel_b = sels[1];

endmodule

// File: rtl/ri_operand_path.sv
module ri_operand_path
    import ri_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  done_t  wb,
    input  ridx_t  rd_a,
    input  ridx_t  rd_b,
    input  opsel_e sel_a,
    input  opsel_e sel_b,
    input  word_t  m_res,
    output word_t  opa,
    output word_t  opb
);

    word_t rf [NREGS];
    word_t rf_a;
    word_t rf_b;

    // write at the end of the writeback cycle: decode sees it one cycle later
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NREGS); i++) rf[i] <= '0;
        end else if (wb.valid && wb.wen && (wb.dst != '0)) begin
            rf[wb.dst] <= wb.res;
        end
    end

    assign rf_a = (rd_a == '0) ? '0 : rf[rd_a];
    assign rf_b = (rd_b == '0) ? '0 : rf[rd_b];

    assign opa = pick_word(sel_a, rf_a, m_res, wb.res);
    assign opb = pick_word(sel_b, rf_b, m_res, wb.res);

endmodule

// File: rtl/ri_stage_track.sv
module ri_stage_track
    import ri_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  exec_t x_in,
    output tag_t  tag_x,
    output tag_t  tag_m,
    output tag_t  tag_w,
    output word_t m_res,
    output done_t w_q
);

    exec_t x_q;
    done_t m_q;
    word_t x_res;

    assign x_res = x_q.opa + x_q.opb + x_q.imm;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            m_q <= '0;
            w_q <= '0;
        end else begin
            x_q <= x_in;
            m_q <= '{valid: x_q.valid, wen: x_q.wen, dst: x_q.dst, res: x_res};
            w_q <= m_q;
        end
    end

    assign tag_x = '{valid: x_q.valid, wen: x_q.wen, dst: x_q.dst};
    assign tag_m = '{valid: m_q.valid, wen: m_q.wen, dst: m_q.dst};
    assign tag_w = '{valid: w_q.valid, wen: w_q.wen, dst: w_q.dst};
    assign m_res = m_q.res;

endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
    import ri_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  policy_bypass,
    input  logic                  in_valid,
    input  logic                  in_wen,
    input  logic [RIDX_W-1:0]     in_dst,
    input  logic [RIDX_W-1:0]     in_src_a,
    input  logic [RIDX_W-1:0]     in_src_b,
    input  logic [DATA_W-1:0]     in_imm,
    output logic                  fetch_hold,
    output logic                  decode_hold,
    output logic                  ex_bubble,
    output logic [1:0]            sel_a,
    output logic [1:0]            sel_b,
    output logic                  wb_valid,
    output logic [RIDX_W-1:0]     wb_dst,
    output logic [DATA_W-1:0]     wb_data
);

    instr_t fetch_q;
    instr_t dec_q;
    exec_t  x_in;
    tag_t   tag_x;
    tag_t   tag_m;
    tag_t   tag_w;
    word_t  m_res;
    done_t  w_q;
    logic   stall;
    opsel_e sa;
    opsel_e sb;
    word_t  opa;
    word_t  opb;

    // fetch and decode registers freeze together while the interlock is active
    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q <= '0;
            dec_q   <= '0;
        end else if (!stall) begin
            fetch_q <= '{valid: in_valid, wen: in_wen, dst: in_dst,
                         src_a: in_src_a, src_b: in_src_b, imm: in_imm};
            dec_q   <= fetch_q;
        end
    end

    ri_hazard_detect u_detect (
        .fwd_en    (policy_bypass),
        .dec_valid (dec_q.valid),
        .dec_src_a (dec_q.src_a),
        .dec_src_b (dec_q.src_b),
        .tag_x     (tag_x),
        .tag_m     (tag_m),
        .tag_w     (tag_w),
        .stall     (stall),
        .sel_a     (sa),
        .sel_b     (sb)
    );

    ri_operand_path u_opnd (
        .clk   (clk),
        .rst   (rst),
        .wb    (w_q),
        .rd_a  (dec_q.src_a),
        .rd_b  (dec_q.src_b),
        .sel_a (sa),
        .sel_b (sb),
        .m_res (m_res),
        .opa   (opa),
        .opb   (opb)
    );

    // a held cycle sends an empty slot into execute
    always_comb begin
        if (stall) x_in = '0;
        else       x_in = '{valid: dec_q.valid, wen: dec_q.wen, dst: dec_q.dst,
                            opa: opa, opb: opb, imm: dec_q.imm};
    end

    ri_stage_track u_track (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .tag_x (tag_x),
        .tag_m (tag_m),
        .tag_w (tag_w),
        .m_res (m_res),
        .w_q   (w_q)
    );

    assign fetch_hold  = stall;
    assign decode_hold = stall;
    assign ex_bubble   = stall;
    assign sel_a       = sa;
    assign sel_b       = sb;
    assign wb_valid    = w_q.valid;
    assign wb_dst      = w_q.dst;
    assign wb_data     = w_q.res;

endmodule

// File: rtl/ri_interlock_checker.sv
module ri_interlock_checker
    import ri_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         fwd_en,
    input logic         fetch_hold,
    input logic         decode_hold,
    input logic         ex_bubble,
    input logic [1:0]   sel_a,
    input logic [1:0]   sel_b,
    input logic         d_valid,
    input instr_t       d_word,
    input logic         x_valid
);

    assert_holds_agree_R7: assert property (@(posedge clk) disable iff (rst)
        fetch_hold == decode_hold);

    assert_bubble_on_hold_R8: assert property (@(posedge clk) disable iff (rst)
        decode_hold |-> ex_bubble);

    assert_execute_empty_R8: assert property (@(posedge clk) disable iff (rst)
        decode_hold |=> !x_valid);

    assert_decode_kept_R2: assert property (@(posedge clk) disable iff (rst)
        decode_hold |=> $stable(d_word));

    assert_single_hold_fwd_R4: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && decode_hold) |=> !decode_hold);

    assert_no_sel_interlock_R5: assert property (@(posedge clk) disable iff (rst)
        !fwd_en |-> (sel_a == 2'd0 && sel_b == 2'd0));

    assert_sel_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (sel_a != 2'd3) && (sel_b != 2'd3));

    assert_hold_needs_instr_R6: assert property (@(posedge clk) disable iff (rst)
        decode_hold |-> d_valid);

endmodule

bind raw_interlock ri_interlock_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .fwd_en      (policy_bypass),
    .fetch_hold  (fetch_hold),
    .decode_hold (decode_hold),
    .ex_bubble   (ex_bubble),
    .sel_a       (sel_a),
    .sel_b       (sel_b),
    .d_valid     (dec_q.valid),
    .d_word      (dec_q),
    .x_valid     (tag_x.valid)
);

// File: tb/raw_interlock_bench.sv
module raw_interlock_bench;
    import ri_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        policy_bypass;
    logic        in_valid;
    logic        in_wen;
    ridx_t       in_dst;
    ridx_t       in_src_a;
    ridx_t       in_src_b;
    word_t       in_imm;
    logic        fetch_hold;
    logic        decode_hold;
    logic        ex_bubble;
    logic [1:0]  sel_a;
    logic [1:0]  sel_b;
    logic        wb_valid;
    ridx_t       wb_dst;
    word_t       wb_data;

    raw_interlock u_raw_interlock (
        .clk(clk), .rst(rst), .policy_bypass(policy_bypass),
        .in_valid(in_valid), .in_wen(in_wen), .in_dst(in_dst),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_imm(in_imm),
        .fetch_hold(fetch_hold), .decode_hold(decode_hold), .ex_bubble(ex_bubble),
        .sel_a(sel_a), .sel_b(sel_b), .wb_valid(wb_valid), .wb_dst(wb_dst),
        .wb_data(wb_data)
    );

    typedef struct { ridx_t dst; word_t data; } exp_t;
    exp_t   sb_q[$];
    int     vectors = 0;
    int     misses  = 0;
    instr_t prog [8];
    int     plen;
    word_t  grf [NREGS];
    logic   done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic instr_t mk(input logic wen, input int dst, input int a,
                                  input int b, input int imm);
        return '{valid: 1'b1, wen: wen, dst: ridx_t'(dst), src_a: ridx_t'(a),
                 src_b: ridx_t'(b), imm: word_t'(imm)};
    endfunction

    // monitor: pop and compare each retirement (R8 order, R9 value)
    always @(negedge clk) begin
        exp_t e;
        if (!rst && wb_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8", "retire with nothing outstanding", int'(wb_dst), -1);
            end else begin
                e = sb_q.pop_front();
                check(wb_dst == e.dst, "R8", "retire destination", int'(wb_dst), int'(e.dst));
                check(wb_data == e.data, "R9", "retire data", int'(wb_data), int'(e.data));
            end
        end
    end

    // driver: push the program-order expectation when an instruction is taken
    task automatic push_expect(input instr_t ins);
        exp_t  e;
        word_t va = (ins.src_a == '0) ? '0 : grf[ins.src_a];
        word_t vb = (ins.src_b == '0) ? '0 : grf[ins.src_b];
        e.dst  = ins.dst;
        e.data = va + vb + ins.imm;
        if (ins.wen && ins.dst != '0) grf[ins.dst] = e.data;  // R10 r0 discarded
        sb_q.push_back(e);
    endtask

    task automatic load(input int p);
        case (p)
            0: begin // back-to-back dependence
                prog[0] = mk(1, 1, 0, 0, 5);
                prog[1] = mk(1, 2, 1, 1, 0);
                plen = 2;
            end
            1: begin // one unrelated instruction in between
                prog[0] = mk(1, 3, 0, 0, 11);
                prog[1] = mk(1, 4, 0, 0, 1);
                prog[2] = mk(1, 5, 3, 0, 1);
                plen = 3;
            end
            2: begin // two unrelated instructions in between
                prog[0] = mk(1, 3, 0, 0, 20);
                prog[1] = mk(1, 4, 0, 0, 2);
                prog[2] = mk(1, 6, 0, 0, 3);
                prog[3] = mk(1, 7, 0, 3, 4);
                plen = 4;
            end
            3: begin // two writers of r1; younger must win
                prog[0] = mk(1, 1, 0, 0, 7);
                prog[1] = mk(1, 1, 0, 0, 9);
                prog[2] = mk(1, 2, 1, 1, 0);
                plen = 3;
            end
            4: begin // r0 destination and non-writing instruction
                prog[0] = mk(1, 0, 0, 0, 5);
                prog[1] = mk(1, 2, 0, 0, 1);
                prog[2] = mk(0, 5, 0, 0, 7);
                prog[3] = mk(1, 6, 5, 5, 2);
                plen = 4;
            end
            default: begin // chain using both operands
                prog[0] = mk(1, 1, 0, 0, 3);
                prog[1] = mk(1, 2, 1, 0, 1);
                prog[2] = mk(1, 3, 2, 1, 2);
                plen = 3;
            end
        endcase
    endtask

    task automatic run_prog(input int p, input logic fwd, input int exp_stall,
                            input int exp_mem, input int exp_wb);
        int idx = 0;
        int stalls = 0;
        int fholds = 0;
        int bubbles = 0;
        int msel = 0;
        int wsel = 0;
        string req = fwd ? "R4" : "R3";
        load(p);
        for (int r = 0; r < int'(NREGS); r++) grf[r] = '0;
        sb_q.delete();
        @(negedge clk);
        rst = 1'b1; policy_bypass = fwd; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (decode_hold) stalls++;
            if (fetch_hold)  fholds++;
            if (ex_bubble)   bubbles++;
            if (sel_a == 2'd1 || sel_b == 2'd1) msel++;
            if (sel_a == 2'd2 || sel_b == 2'd2) wsel++;
            if (idx < plen) begin
                in_valid = 1'b1; in_wen = prog[idx].wen; in_dst = prog[idx].dst;
                in_src_a = prog[idx].src_a; in_src_b = prog[idx].src_b;
                in_imm = prog[idx].imm;
                if (!fetch_hold) begin  // R7: taken at the next edge
                    push_expect(prog[idx]);
                    idx++;
                end
            end else begin
                in_valid = 1'b0;
            end
        end
        if (p == 0 && !fwd) req = "R2";
        if (p == 4) req = "R6";
        check(stalls == exp_stall, req, $sformatf("held cycles prog %0d mode %0d", p, fwd),
              stalls, exp_stall);
        check(fholds == stalls, "R7", "fetch hold cycles", fholds, stalls);
        check(bubbles == stalls, "R8", "bubble cycles", bubbles, stalls);
        check(msel == exp_mem, "R5", $sformatf("memory select cycles prog %0d mode %0d", p, fwd),
              msel, exp_mem);
        check(wsel == exp_wb, "R5", $sformatf("writeback select cycles prog %0d mode %0d", p, fwd),
              wsel, exp_wb);
        check(sb_q.size() == 0, "R8", "instructions never retired", sb_q.size(), 0);
    endtask

    // expected: held cycles, memory-select cycles, writeback-select cycles
    int e_st [6][2] = '{'{3, 1}, '{2, 0}, '{1, 0}, '{3, 1}, '{0, 0}, '{6, 2}};
    int e_ms [6][2] = '{'{0, 1}, '{0, 1}, '{0, 0}, '{0, 2}, '{0, 0}, '{0, 2}};
    int e_wb [6][2] = '{'{0, 0}, '{0, 0}, '{0, 1}, '{0, 0}, '{0, 0}, '{0, 1}};

    initial begin
        rst = 1'b1; policy_bypass = 1'b1;
        in_valid = 1'b1; in_wen = 1'b1; in_dst = 3'd1;
        in_src_a = 3'd1; in_src_b = 3'd1; in_imm = 16'h1234;
        repeat (3) @(negedge clk);
        // R1: reset state with an instruction present at the input
        check(!fetch_hold && !decode_hold, "R1", "holds in reset",
              int'(fetch_hold) + int'(decode_hold), 0);
        check(!ex_bubble && !wb_valid, "R1", "bubble/writeback in reset",
              int'(ex_bubble) + int'(wb_valid), 0);
        check(sel_a == 2'd0 && sel_b == 2'd0, "R1", "selects in reset",
              int'(sel_a) + int'(sel_b), 0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(!decode_hold && !wb_valid, "R1", "first cycle after reset",
              int'(decode_hold) + int'(wb_valid), 0);
        for (int p = 0; p < 6; p++) begin
            for (int m = 0; m < 2; m++) begin
                run_prog(p, m[0], e_st[p][m], e_ms[p][m], e_wb[p][m]);
            end
        end
        // R10: after a fresh reset a reader of r4 and r0 sees zero
        load(4);
        @(negedge clk);
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        for (int r = 0; r < int'(NREGS); r++) grf[r] = '0;
        in_valid = 1'b1; in_wen = 1'b1; in_dst = 3'd2;
        in_src_a = 3'd4; in_src_b = 3'd0; in_imm = 16'd0;
        push_expect(mk(1, 2, 4, 0, 0));
        @(negedge clk);
        in_valid = 1'b0;
        repeat (8) @(negedge clk);
        check(sb_q.size() == 0, "R10", "cleared-register read retired", sb_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule